// File: doc/BRIEF.md
# Dual-Bus Address Decode and Byte-Lane Steering

This block sits between the memory request port of a 32-bit stack CPU and two downstream buses: a plain system bus and a Wishbone-style bus. Each request carries an address, write data, a read/write flag and an access size (byte, half-word or word). The bit just above the configured maximum address bit chooses the bus. Both buses see an identical address region. In each region the top window of the address space is marked as IO, and the request reports that flag when it completes.

Byte lanes are big-endian. For writes, the block places the data in the addressed lane and raises the matching byte enables. For reads, it extracts the addressed lane and zero-extends it. A build parameter can remove the sub-word write hardware. In that build, a byte or half-word store becomes a word read, a merge of the new lane into the old word, and a word write of the merged value. The request side uses a valid/ready handshake and returns a one-cycle done pulse.

Top module: `dual_bus_steer`

## Requirements
- R1: With the Wishbone bus enabled, address bit ADDR_MSB+1 (bit 24 by default) selects the bus: 0 selects the system bus and 1 selects the Wishbone bus. Only the selected bus strobes. The bus address carries bits ADDR_MSB..2 of the request, with bits 1..0 driven as zero.
- R2: The IO flag is set when address bits ADDR_MSB..IO_BITS (23..16 by default) are all ones, in either region. It is presented on `rsp_io` while `rsp_done` is high.
- R3: Size codes 2 and 3 are word accesses. A word access ignores address bits 1..0, enables all four lanes (1111) and transfers the full 32-bit word.
- R4: Size code 0 is a byte access. A byte write at offset o raises the single enable bit 3-o and places data bits 7..0 in that lane. Offset 0 maps to bits 31..24 and offset 3 maps to bits 7..0. All other lanes are zero.
- R5: Size code 1 is a half-word access, and it ignores address bit 0. When address bit 1 is 0, a write uses enables 1100 with data bits 15..0 in bits 31..16. When address bit 1 is 1, it uses enables 0011 with the data in bits 15..0.
- R6: A byte or half-word read returns the addressed lane, chosen as in R4/R5, zero-extended to 32 bits. A word read returns the whole word.
- R7: `req_ready` is high only while no request is in progress. A request is taken on `req_valid` and `req_ready` together. A bus strobe holds its address until acknowledged. `rsp_done` is a single-cycle pulse in the cycle after the final acknowledge. `rsp_rdata` holds its value until the next completion.
- R8: With SUBWORD_HW=0, a sub-word store issues a word read with enables 1111. It then writes back the read word, with only the addressed lane replaced, using enables 1111. The other bytes of that word are preserved.
- R9: With zero-wait buses, a sub-word store on the fallback path completes exactly 3 cycles later than the same store through byte enables.
- R10: During and right after reset, `req_ready` is 1, `rsp_done` is 0, neither bus strobes, and `rsp_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request accepted this cycle |
| req_addr | input | ADDR_MSB+2 | Byte address, top bit selects the bus |
| req_wdata | input | 32 | Store data, right-aligned |
| req_we | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 half-word, 2 or 3 word |
| rsp_done | output | 1 | Completion pulse |
| rsp_rdata | output | 32 | Read result, zero-extended |
| rsp_io | output | 1 | Completed access hit an IO window |
| sys_cyc | output | 1 | System bus strobe |
| sys_we | output | 1 | System bus write |
| sys_addr | output | ADDR_MSB+1 | System bus word address |
| sys_wdata | output | 32 | System bus write data |
| sys_be | output | 4 | System bus byte enables |
| sys_rdata | input | 32 | System bus read data |
| sys_ack | input | 1 | System bus acknowledge |
| wb_cyc | output | 1 | Wishbone cycle |
| wb_stb | output | 1 | Wishbone strobe |
| wb_we | output | 1 | Wishbone write |
| wb_adr | output | ADDR_MSB+1 | Wishbone word address |
| wb_dat_o | output | 32 | Wishbone write data |
| wb_sel | output | 4 | Wishbone lane selects |
| wb_dat_i | input | 32 | Wishbone read data |
| wb_ack | input | 1 | Wishbone acknowledge |

## Verification
The hardest case is the fallback store. Here the old word must be fetched, merged and written back, and every byte outside the lane must survive, on either bus and while the slave inserts wait states. The bench runs a second instance built without sub-word hardware next to the main one. Both instances get the same random mix of sizes, offsets, buses and wait counts. Each slave model's memory is compared with a merge the bench computes itself. The three-cycle penalty is measured directly by running the same byte store through both instances with zero-wait slaves.

// File: rtl/dual_bus_steer.sv
module dual_bus_steer #(
  parameter int ADDR_MSB   = 23,
  parameter int IO_BITS    = 16,
  parameter int WB_EN      = 1,
  parameter int SUBWORD_HW = 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [ADDR_MSB+1:0] req_addr,
  input  logic [31:0]         req_wdata,
  input  logic                req_we,
  input  logic [1:0]          req_size,
  output logic                rsp_done,
  output logic [31:0]         rsp_rdata,
  output logic                rsp_io,
  output logic                sys_cyc,
  output logic                sys_we,
  output logic [ADDR_MSB:0]   sys_addr,
  output logic [31:0]         sys_wdata,
  output logic [3:0]          sys_be,
  input  logic [31:0]         sys_rdata,
  input  logic                sys_ack,
  output logic                wb_cyc,
  output logic                wb_stb,
  output logic                wb_we,
  output logic [ADDR_MSB:0]   wb_adr,
  output logic [31:0]         wb_dat_o,
  output logic [3:0]          wb_sel,
  input  logic [31:0]         wb_dat_i,
  input  logic                wb_ack
);
  localparam int SEL_BIT = ADDR_MSB + 1;

  typedef enum logic [2:0] {S_IDLE, S_ACC, S_RMW_RD, S_RMW_MRG, S_RMW_GAP, S_RMW_WR, S_RESP} st_t;

  function automatic logic [3:0] lane_en(input logic [1:0] o, input logic [1:0] sz);
    case (sz)
      2'd0:    return 4'b1000 >> o;
      2'd1:    return o[1] ? 4'b0011 : 4'b1100;
      default: return 4'b1111;
    endcase
  endfunction

  function automatic logic [31:0] lane_put(input logic [31:0] w, input logic [1:0] o, input logic [1:0] sz);
    logic [31:0] t;
    t = {24'h0, w[7:0]};
    case (sz)
      2'd0:    return t << {~o, 3'b000};
      2'd1:    return o[1] ? {16'h0, w[15:0]} : {w[15:0], 16'h0};
      default: return w;
    endcase
  endfunction

  function automatic logic [31:0] lane_get(input logic [31:0] d, input logic [1:0] o, input logic [1:0] sz);
    logic [31:0] t;
    t = d >> {~o, 3'b000};
    case (sz)
      2'd0:    return {24'h0, t[7:0]};
      2'd1:    return o[1] ? {16'h0, d[15:0]} : {16'h0, d[31:16]};
      default: return d;
    endcase
  endfunction

  function automatic logic [31:0] be_mask(input logic [3:0] be);
    return {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
  endfunction

  st_t                state;
  logic [ADDR_MSB:2]  r_adr;
  logic [1:0]         r_off, r_size;
  logic               r_we, r_wb;
  logic [3:0]         r_be;
  logic [31:0]        r_wdata, wbuf;

  wire take    = req_valid && req_ready;
  wire sub_st  = req_we && !req_size[1];
  wire use_rmw = (SUBWORD_HW == 0) && sub_st;
  wire hit_io  = &req_addr[ADDR_MSB:IO_BITS];
  wire to_wb   = (WB_EN != 0) && req_addr[SEL_BIT];

  wire        bus_ack = r_wb ? wb_ack : sys_ack;
  wire [31:0] bus_din = r_wb ? wb_dat_i : sys_rdata;
  wire        active  = (state == S_ACC) || (state == S_RMW_RD) || (state == S_RMW_WR);
  wire        bus_wr  = ((state == S_ACC) && r_we) || (state == S_RMW_WR);
  wire [3:0]  bus_be  = (SUBWORD_HW != 0) ? r_be : 4'hF;
  wire [31:0] bus_do  = (state == S_RMW_WR) ? wbuf : r_wdata;

  assign req_ready = (state == S_IDLE);
  assign rsp_done  = (state == S_RESP);

  assign sys_cyc   = active && !r_wb;
  assign sys_we    = bus_wr;
  assign sys_addr  = {r_adr, 2'b00};
  assign sys_wdata = bus_do;
  assign sys_be    = bus_be;
  assign wb_cyc    = active && r_wb;
  assign wb_stb    = active && r_wb;
  assign wb_we     = bus_wr;
  assign wb_adr    = {r_adr, 2'b00};
  assign wb_dat_o  = bus_do;
  assign wb_sel    = bus_be;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      r_adr     <= '0;
      r_off     <= '0;
      r_size    <= '0;
      r_we      <= 1'b0;
      r_wb      <= 1'b0;
      r_be      <= '0;
      r_wdata   <= '0;
      wbuf      <= '0;
      rsp_rdata <= '0;
      rsp_io    <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (take) begin
          r_adr   <= req_addr[ADDR_MSB:2];
          r_off   <= req_addr[1:0];
          r_size  <= req_size;
          r_we    <= req_we;
          r_wb    <= to_wb;
          r_be    <= lane_en(req_addr[1:0], req_size);
          r_wdata <= lane_put(req_wdata, req_addr[1:0], req_size);
          rsp_io  <= hit_io;
          state   <= use_rmw ? S_RMW_RD : S_ACC;
        end
        S_ACC: if (bus_ack) begin
          if (!r_we) rsp_rdata <= lane_get(bus_din, r_off, r_size);
          state <= S_RESP;
        end
        S_RMW_RD: if (bus_ack) begin
          wbuf  <= bus_din;
          state <= S_RMW_MRG;
        end
        S_RMW_MRG: begin
          wbuf  <= (wbuf & ~be_mask(r_be)) | r_wdata;
          state <= S_RMW_GAP;
        end
        S_RMW_GAP: state <= S_RMW_WR;
        S_RMW_WR:  if (bus_ack) state <= S_RESP;
        default:   state <= S_IDLE;
      endcase
    end
  end

  // R7
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);

  // R7
  sys_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sys_cyc && !sys_ack |=> sys_cyc && $stable(sys_addr) && $stable(sys_we));

  // R7
  wb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_cyc && !wb_ack |=> wb_cyc && $stable(wb_adr) && $stable(wb_we));

  // R7
  done_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> $past((sys_cyc && sys_ack) || (wb_cyc && wb_ack)));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done && req_ready);

  // R1
  single_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !(sys_cyc && wb_cyc));
endmodule

// File: tb/dual_bus_steer_test.sv
module bus_model (
  input  logic        clk,
  input  logic        cyc,
  input  logic        we,
  input  logic [3:0]  idx,
  input  logic [31:0] wd,
  input  logic [3:0]  be,
  input  logic [1:0]  waits,
  output logic [31:0] rd,
  output logic        ack
);
  logic [31:0] mem [16];
  int          cnt = 0;
  int          n_wr = 0;
  int          n_rd = 0;
  logic [3:0]  last_be = 4'h0;

  assign ack = cyc && (cnt >= int'(waits));
  assign rd  = mem[idx];

  always @(posedge clk) begin
    if (cyc) begin
      if (ack) begin
        cnt <= 0;
        if (we) begin
          for (int k = 0; k < 4; k++)
            if (be[k]) mem[idx][8*k +: 8] <= wd[8*k +: 8];
          n_wr    <= n_wr + 1;
          last_be <= be;
        end else begin
          n_rd <= n_rd + 1;
        end
      end else begin
        cnt <= cnt + 1;
      end
    end
  end
endmodule

module dual_bus_steer_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [24:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        req_we = 1'b0;
  logic [1:0]  req_size = 2'd0;
  logic        v0 = 1'b0, v1 = 1'b0;
  logic [1:0]  wt = 2'd0;

  logic        rdy0, dn0, io0, sc0, swe0, wc0, ws0, wwe0, sak0, wak0;
  logic [31:0] rd0, swd0, srd0, wwd0, wrd0;
  logic [23:0] sa0, wa0;
  logic [3:0]  sbe0, wbe0;
  logic        rdy1, dn1, io1, sc1, swe1, wc1, ws1, wwe1, sak1, wak1;
  logic [31:0] rd1, swd1, srd1, wwd1, wrd1;
  logic [23:0] sa1, wa1;
  logic [3:0]  sbe1, wbe1;

  dual_bus_steer uut (
    .clk(clk), .rst_n(rst_n), .req_valid(v0), .req_ready(rdy0), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_we(req_we), .req_size(req_size), .rsp_done(dn0),
    .rsp_rdata(rd0), .rsp_io(io0), .sys_cyc(sc0), .sys_we(swe0), .sys_addr(sa0),
    .sys_wdata(swd0), .sys_be(sbe0), .sys_rdata(srd0), .sys_ack(sak0), .wb_cyc(wc0),
    .wb_stb(ws0), .wb_we(wwe0), .wb_adr(wa0), .wb_dat_o(wwd0), .wb_sel(wbe0),
    .wb_dat_i(wrd0), .wb_ack(wak0));

  dual_bus_steer #(.SUBWORD_HW(0)) uut_rmw (
    .clk(clk), .rst_n(rst_n), .req_valid(v1), .req_ready(rdy1), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_we(req_we), .req_size(req_size), .rsp_done(dn1),
    .rsp_rdata(rd1), .rsp_io(io1), .sys_cyc(sc1), .sys_we(swe1), .sys_addr(sa1),
    .sys_wdata(swd1), .sys_be(sbe1), .sys_rdata(srd1), .sys_ack(sak1), .wb_cyc(wc1),
    .wb_stb(ws1), .wb_we(wwe1), .wb_adr(wa1), .wb_dat_o(wwd1), .wb_sel(wbe1),
    .wb_dat_i(wrd1), .wb_ack(wak1));

  bus_model s_sys0 (.clk(clk), .cyc(sc0), .we(swe0), .idx(sa0[5:2]), .wd(swd0), .be(sbe0), .waits(wt), .rd(srd0), .ack(sak0));
  bus_model s_wb0  (.clk(clk), .cyc(wc0), .we(wwe0), .idx(wa0[5:2]), .wd(wwd0), .be(wbe0), .waits(wt), .rd(wrd0), .ack(wak0));
  bus_model s_sys1 (.clk(clk), .cyc(sc1), .we(swe1), .idx(sa1[5:2]), .wd(swd1), .be(sbe1), .waits(wt), .rd(srd1), .ack(sak1));
  bus_model s_wb1  (.clk(clk), .cyc(wc1), .we(wwe1), .idx(wa1[5:2]), .wd(wwd1), .be(wbe1), .waits(wt), .rd(wrd1), .ack(wak1));

  int n_chk = 0;
  int n_fail = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [3:0] e_be(input logic [24:0] a, input logic [1:0] sz);
    if (sz[1]) return 4'hF;
    if (sz == 2'd1) return a[1] ? 4'h3 : 4'hC;
    return 4'(1 << (3 - int'(a[1:0])));
  endfunction

  function automatic logic [31:0] e_lane(input logic [31:0] d, input logic [24:0] a, input logic [1:0] sz);
    logic [31:0] r;
    logic [3:0]  en;
    if (sz[1]) return d;
    if (sz == 2'd1) return a[1] ? {16'h0, d[15:0]} : {d[15:0], 16'h0};
    en = e_be(a, sz);
    r = '0;
    for (int k = 0; k < 4; k++) if (en[k]) r[8*k +: 8] = d[7:0];
    return r;
  endfunction

  function automatic logic [31:0] e_merge(input logic [31:0] old, input logic [31:0] nw, input logic [3:0] en);
    logic [31:0] r;
    r = old;
    for (int k = 0; k < 4; k++) if (en[k]) r[8*k +: 8] = nw[8*k +: 8];
    return r;
  endfunction

  function automatic logic [31:0] e_rd(input logic [31:0] w, input logic [24:0] a, input logic [1:0] sz);
    if (sz[1]) return w;
    if (sz == 2'd1) return a[1] ? (w & 32'h0000FFFF) : (w >> 16);
    return (w >> (8 * (3 - int'(a[1:0])))) & 32'hFF;
  endfunction

  logic        r_busy_rdy, r_scyc, r_wcyc, r_io, r_done_after;
  logic [23:0] r_badr;
  logic [31:0] r_rd, r_rd_held;
  int          r_lat;

  task automatic run(input bit r, input logic [24:0] a, input logic [31:0] d,
                     input logic w, input logic [1:0] sz);
    @(negedge clk);
    req_addr = a; req_wdata = d; req_we = w; req_size = sz;
    if (r) v1 = 1'b1; else v0 = 1'b1;
    @(negedge clk);
    v0 = 1'b0; v1 = 1'b0;
    r_busy_rdy = r ? rdy1 : rdy0;
    r_scyc = r ? sc1 : sc0;
    r_wcyc = r ? wc1 : wc0;
    r_badr = a[24] ? (r ? wa1 : wa0) : (r ? sa1 : sa0);
    r_lat = 1;
    while (!(r ? dn1 : dn0) && r_lat < 60) begin
      @(negedge clk);
      r_lat++;
    end
    r_rd = r ? rd1 : rd0;
    r_io = r ? io1 : io0;
    @(negedge clk);
    r_done_after = r ? dn1 : dn0;
    r_rd_held = r ? rd1 : rd0;
  endtask

  task automatic access(input bit r, input logic [24:0] a, input logic [31:0] d,
                        input logic w, input logic [1:0] sz);
    logic [3:0]  idx;
    logic [31:0] old, nw;
    int          rd_b, wr_b, oth_b, rd_a, wr_a, oth_a;
    logic [3:0]  lbe;
    string       tag;
    idx = a[5:2];
    tag = !w ? "R6" : sz[1] ? "R3" : (sz == 2'd1) ? "R5" : "R4";
    if (!r) begin
      old  = a[24] ? s_wb0.mem[idx] : s_sys0.mem[idx];
      rd_b = a[24] ? s_wb0.n_rd : s_sys0.n_rd;
      wr_b = a[24] ? s_wb0.n_wr : s_sys0.n_wr;
      oth_b = a[24] ? s_sys0.n_rd + s_sys0.n_wr : s_wb0.n_rd + s_wb0.n_wr;
    end else begin
      old  = a[24] ? s_wb1.mem[idx] : s_sys1.mem[idx];
      rd_b = a[24] ? s_wb1.n_rd : s_sys1.n_rd;
      wr_b = a[24] ? s_wb1.n_wr : s_sys1.n_wr;
      oth_b = a[24] ? s_sys1.n_rd + s_sys1.n_wr : s_wb1.n_rd + s_wb1.n_wr;
    end
    run(r, a, d, w, sz);
    if (!r) begin
      nw   = a[24] ? s_wb0.mem[idx] : s_sys0.mem[idx];
      rd_a = a[24] ? s_wb0.n_rd : s_sys0.n_rd;
      wr_a = a[24] ? s_wb0.n_wr : s_sys0.n_wr;
      oth_a = a[24] ? s_sys0.n_rd + s_sys0.n_wr : s_wb0.n_rd + s_wb0.n_wr;
      lbe  = a[24] ? s_wb0.last_be : s_sys0.last_be;
    end else begin
      nw   = a[24] ? s_wb1.mem[idx] : s_sys1.mem[idx];
      rd_a = a[24] ? s_wb1.n_rd : s_sys1.n_rd;
      wr_a = a[24] ? s_wb1.n_wr : s_sys1.n_wr;
      oth_a = a[24] ? s_sys1.n_rd + s_sys1.n_wr : s_wb1.n_rd + s_wb1.n_wr;
      lbe  = a[24] ? s_wb1.last_be : s_sys1.last_be;
    end
    check(r_lat < 60, "R7", "completion seen", 32'(r_lat), 32'd0);
    check(!r_busy_rdy, "R7", "ready low while busy", {31'h0, r_busy_rdy}, 32'h0);
    check(!r_done_after && r_rd_held == r_rd, "R7", "done pulse one cycle, rdata held",
          r_rd_held, r_rd);
    check(r_scyc == !a[24] && r_wcyc == a[24], "R1", "bus strobe select",
          {30'h0, r_wcyc, r_scyc}, {30'h0, a[24], !a[24]});
    check(r_badr == {a[23:2], 2'b00}, "R1", "bus address", {8'h0, r_badr}, {8'h0, a[23:2], 2'b00});
    check(oth_a == oth_b, "R1", "other bus untouched", 32'(oth_a - oth_b), 32'd0);
    check(r_io == (&a[23:16]), "R2", "io flag", {31'h0, r_io}, {31'h0, &a[23:16]});
    if (w) begin
      check(nw == e_merge(old, e_lane(d, a, sz), e_be(a, sz)), r && !sz[1] ? "R8" : tag,
            "memory after write", nw, e_merge(old, e_lane(d, a, sz), e_be(a, sz)));
      if (r) begin
        check(lbe == 4'hF, "R8", "fallback write enables", {28'h0, lbe}, 32'hF);
        check(rd_a - rd_b == (sz[1] ? 0 : 1), "R8", "fallback read count",
              32'(rd_a - rd_b), sz[1] ? 32'd0 : 32'd1);
      end else begin
        check(lbe == e_be(a, sz), tag, "byte enables", {28'h0, lbe}, {28'h0, e_be(a, sz)});
      end
      check(wr_a - wr_b == 1, tag, "one write", 32'(wr_a - wr_b), 32'd1);
    end else begin
      check(r_rd == e_rd(old, a, sz), "R6", "read data", r_rd, e_rd(old, a, sz));
      check(rd_a - rd_b == 1 && wr_a == wr_b, "R6", "one read", 32'(rd_a - rd_b), 32'd1);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int lat_d, lat_r;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 16; i++) begin
      s_sys0.mem[i] = $urandom; s_wb0.mem[i] = $urandom;
      s_sys1.mem[i] = $urandom; s_wb1.mem[i] = $urandom;
    end
    repeat (4) @(negedge clk);
    // R10 reset state
    check(rdy0 && rdy1, "R10", "ready in reset", {30'h0, rdy1, rdy0}, 32'h3);
    check(!dn0 && !dn1 && !sc0 && !wc0 && !sc1 && !wc1, "R10", "no done or strobe in reset",
          {26'h0, dn0, dn1, sc0, wc0, sc1, wc1}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check(rd0 == 32'h0 && rd1 == 32'h0, "R10", "rdata after reset", rd0 | rd1, 32'h0);
    check(rdy0 && !sc0 && !wc0, "R10", "idle after reset", {29'h0, rdy0, sc0, wc0}, 32'h4);

    // R3 word with low bits set
    access(1'b0, 25'h0000013, 32'hA1B2C3D4, 1'b1, 2'd2);
    access(1'b0, 25'h0000012, 32'h0, 1'b0, 2'd3);
    // R4 each byte offset on the Wishbone region
    for (int o = 0; o < 4; o++) access(1'b0, 25'h1000020 + 25'(o), 32'h5A + 32'(o), 1'b1, 2'd0);
    for (int o = 0; o < 4; o++) access(1'b0, 25'h1000020 + 25'(o), 32'h0, 1'b0, 2'd0);
    // R5 half-words including odd offsets
    access(1'b0, 25'h0000101, 32'h1234BEEF, 1'b1, 2'd1);
    access(1'b0, 25'h0000103, 32'h5678CAFE, 1'b1, 2'd1);
    access(1'b0, 25'h0000101, 32'h0, 1'b0, 2'd1);
    access(1'b0, 25'h0000102, 32'h0, 1'b0, 2'd1);
    // R2 IO windows in both regions
    access(1'b0, 25'h0FF1234, 32'h0, 1'b0, 2'd2);
    access(1'b0, 25'h1FF0008, 32'h77, 1'b1, 2'd0);
    access(1'b0, 25'h0FE0008, 32'h0, 1'b0, 2'd2);
    // R8 fallback merges on both buses
    access(1'b1, 25'h0000041, 32'hC3, 1'b1, 2'd0);
    access(1'b1, 25'h1000046, 32'h9ABC, 1'b1, 2'd1);
    access(1'b1, 25'h0000048, 32'h13572468, 1'b1, 2'd2);

    // R9 latency penalty of the fallback
    wt = 2'd0;
    access(1'b0, 25'h0000052, 32'h11, 1'b1, 2'd0);
    lat_d = r_lat;
    access(1'b1, 25'h0000052, 32'h11, 1'b1, 2'd0);
    lat_r = r_lat;
    check(lat_r - lat_d == 3, "R9", "fallback extra cycles", 32'(lat_r - lat_d), 32'd3);

    for (int n = 0; n < 600; n++) begin
      logic [24:0] a;
      a = 25'($urandom);
      if ($urandom % 3 == 0) a[23:16] = 8'hFF;
      wt = 2'($urandom % 3);
      access(1'(n % 2), a, $urandom, 1'($urandom), 2'($urandom % 4));
    end
    finish_run();
  end
endmodule